// File: doc/BRIEF.md
# AHB Boot Copy Writer

This block is the bus side of a boot loader. While the processor is held in reset, a serial flash reader hands it 32-bit words one at a time. The block writes each word to on-chip RAM as a single AHB-Lite write. The address starts at a parameterized, word-aligned base and steps by four bytes for each word.

When the reader reports that the copy is over, the block waits for the data-check stage to finish. It then reads back the first RAM location. That read flushes any posted writes still in flight. It also compares the data with the first word written. If no transfer drew an error response and the read-back matches, the block takes two steps in order. It first gives the flash pins to the host controller. One clock later it releases the processor from reset.

A debug input skips the copy and goes straight to the handover. Both error flags are sticky until the next reset. After any error the processor stays in reset.

Top module: `boot_copy_ahb_writer`

## Requirements
- R1: Every transfer is a single transfer. `htrans` is NONSEQ (2'b10) during an address phase and stays NONSEQ, with `haddr` held, until `hready` is high. In the following cycle it returns to IDLE (2'b00). `hsize` is always 3'b010 and `hburst` is always 3'b000.
- R2: The k-th word accepted after reset (k counted from 0) is written to `BASE_ADDR + 4*k`, with `hwrite` high.
- R3: `word_data[31:24]` is the first flash byte of a word. With `BIG_END=0`, byte lane i of `hwdata` carries byte 3-i of `word_data`, so the first flash byte sits in bits [7:0]. With `BIG_END=1`, `hwdata` equals `word_data` unchanged.
- R4: `hwdata` is valid from the address phase of a write and stays stable until the data phase ends with `hready` high.
- R5: If `hresp` is 1 during any data phase, `err[0]` is set. No further transfer is started, and `host_sel` and `proc_rst_n` stay low until reset.
- R6: After `all_done` goes high, no read is issued until `check_done` is high. Then exactly one read is issued, at `BASE_ADDR`.
- R7: If the read-back data differs from the first word as written to RAM, `err[1]` is set. `host_sel` and `proc_rst_n` stay low, and both error bits hold until reset.
- R8: With no error, `host_sel` rises first and `proc_rst_n` rises exactly one clock later. Both stay high until reset.
- R9: If `debug_bypass` is high while the block is waiting for a word, no bus transfer is made and the R8 handover follows directly.
- R10: While `rst` is high, `htrans` is IDLE, `err` is 0, and `host_sel` and `proc_rst_n` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| debug_bypass | input | 1 | Skip the copy and hand over at once |
| word_valid | input | 1 | One-cycle strobe: `word_data` holds the next word |
| word_data | input | 32 | Word from the flash reader, first byte in [31:24] |
| all_done | input | 1 | Level: the last word has been delivered |
| check_done | input | 1 | Level: the data-check stage has finished |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | AHB write flag |
| hsize | output | 3 | AHB size, fixed at word |
| hburst | output | 3 | AHB burst, fixed at single |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB transfer done |
| hresp | input | 1 | AHB error response |
| err | output | 2 | Bit 0: error response; bit 1: read-back mismatch |
| host_sel | output | 1 | Route the flash pins to the host controller |
| proc_rst_n | output | 1 | Active-low processor reset |

## Verification
The assertions assume that the slave follows AHB-Lite. A data phase is only entered through an accepted NONSEQ, and `hready` stays low for a bounded number of cycles. They also assume that `word_valid` pulses only while the block is idle, waiting for a word.

The bench keeps to these assumptions. It spaces words well beyond the longest write, including the inserted wait states. Its slave model drives `hready` and `hresp` only as AHB-Lite allows, and answers an error with the two-cycle error response. `all_done` and `check_done` are raised as levels after the last word, which is the only order the reader produces.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_WADDR,
    ST_WDATA,
    ST_CHECK,
    ST_RADDR,
    ST_RDATA,
    ST_HAND,
    ST_FIN
  } wr_state_t;

  localparam logic [1:0] TR_IDLE      = 2'b00;
  localparam logic [1:0] TR_NONSEQ    = 2'b10;
  localparam logic [2:0] SIZE_WORD    = 3'b010;
  localparam logic [2:0] BURST_SINGLE = 3'b000;
endpackage

// File: rtl/boot_lane_order.sv
module boot_lane_order #(
  parameter int DATA_W  = 32,
  parameter bit BIG_END = 1'b0
) (
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int LANES = DATA_W / 8;

  generate
    if (BIG_END) begin : g_keep
      assign dout = din;
    end else begin : g_swap
      for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*i +: 8] = din[DATA_W-8-8*i +: 8];
      end
    end
  endgenerate
endmodule

// File: rtl/boot_addr_step.sv
module boot_addr_step #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = '0,
  parameter int                STEP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst) addr <= BASE;
    else if (advance) addr <= addr + INC;
  end
endmodule

// File: rtl/boot_copy_fsm.sv
module boot_copy_fsm
  import boot_copy_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      debug_bypass,
  input  logic      word_valid,
  input  logic      all_done,
  input  logic      check_done,
  input  logic      hready,
  input  logic      hresp,
  input  logic      rd_match,
  output wr_state_t state,
  output logic      ld_word,
  output logic      ld_first,
  output logic      advance,
  output logic [1:0] err,
  output logic      host_sel,
  output logic      proc_rel
);
  wr_state_t state_n;
  logic      first_seen_q;
  logic      set_resp_err, set_cmp_err;

  always_comb begin
    state_n      = state;
    ld_word      = 1'b0;
    advance      = 1'b0;
    set_resp_err = 1'b0;
    set_cmp_err  = 1'b0;
    unique case (state)
      ST_WAIT: begin
        if (debug_bypass) state_n = ST_HAND;
        else if (word_valid) begin
          ld_word = 1'b1;
          state_n = ST_WADDR;
        end else if (all_done) state_n = ST_CHECK;
      end
      ST_WADDR: if (hready) state_n = ST_WDATA;
      ST_WDATA: begin
        if (hresp) begin
          set_resp_err = 1'b1;
          state_n      = ST_FIN;
        end else if (hready) begin
          advance = 1'b1;
          state_n = ST_WAIT;
        end
      end
      ST_CHECK: if (check_done) state_n = ST_RADDR;
      ST_RADDR: if (hready) state_n = ST_RDATA;
      ST_RDATA: begin
        if (hresp) begin
          set_resp_err = 1'b1;
          state_n      = ST_FIN;
        end else if (hready) begin
          if (rd_match) state_n = ST_HAND;
          else begin
            set_cmp_err = 1'b1;
            state_n     = ST_FIN;
          end
        end
      end
      ST_HAND: state_n = ST_FIN;
      default: state_n = ST_FIN;
    endcase
  end

  assign ld_first = ld_word && !first_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_WAIT;
      first_seen_q <= 1'b0;
      err          <= 2'b00;
      host_sel     <= 1'b0;
      proc_rel     <= 1'b0;
    end else begin
      state <= state_n;
      if (ld_word) first_seen_q <= 1'b1;
      if (set_resp_err) err[0] <= 1'b1;
      if (set_cmp_err) err[1] <= 1'b1;
      if (state_n == ST_HAND) host_sel <= 1'b1;
      if (state == ST_HAND) proc_rel <= 1'b1;
    end
  end
endmodule

// File: rtl/boot_copy_ahb_writer.sv
module boot_copy_ahb_writer
  import boot_copy_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter bit                BIG_END   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              debug_bypass,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              all_done,
  input  logic              check_done,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata,
  input  logic [DATA_W-1:0] hrdata,
  input  logic              hready,
  input  logic              hresp,
  output logic [1:0]        err,
  output logic              host_sel,
  output logic              proc_rst_n
);
  localparam int BYTES = DATA_W / 8;

  wr_state_t         state;
  logic              ld_word, ld_first, advance, proc_rel;
  logic [DATA_W-1:0] ordered, word_q, first_q;
  logic [ADDR_W-1:0] wr_addr;
  logic              rd_match;

  boot_lane_order #(.DATA_W(DATA_W), .BIG_END(BIG_END)) u_order (
    .din (word_data),
    .dout(ordered)
  );

  boot_addr_step #(.ADDR_W(ADDR_W), .BASE(BASE_ADDR), .STEP(BYTES)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .advance(advance),
    .addr   (wr_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      first_q <= '0;
    end else begin
      if (ld_word) word_q <= ordered;
      if (ld_first) first_q <= ordered;
    end
  end

  assign rd_match = (hrdata == first_q);

  boot_copy_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .debug_bypass(debug_bypass),
    .word_valid  (word_valid),
    .all_done    (all_done),
    .check_done  (check_done),
    .hready      (hready),
    .hresp       (hresp),
    .rd_match    (rd_match),
    .state       (state),
    .ld_word     (ld_word),
    .ld_first    (ld_first),
    .advance     (advance),
    .err         (err),
    .host_sel    (host_sel),
    .proc_rel    (proc_rel)
  );

  assign htrans     = (state == ST_WADDR || state == ST_RADDR) ? TR_NONSEQ : TR_IDLE;
  assign hwrite     = (state == ST_WADDR);
  assign haddr      = (state == ST_RADDR) ? BASE_ADDR : wr_addr;
  assign hwdata     = word_q;
  assign hsize      = SIZE_WORD;
  assign hburst     = BURST_SINGLE;
  assign proc_rst_n = proc_rel;
endmodule

// File: rtl/boot_copy_ahb_writer_chk.sv
module boot_copy_ahb_writer_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] haddr,
  input logic [1:0]        htrans,
  input logic              hwrite,
  input logic [DATA_W-1:0] hwdata,
  input logic              hready,
  input logic [1:0]        err,
  input logic              host_sel,
  input logic              proc_rst_n
);
  logic dp_wr_q;

  always_ff @(posedge clk) begin
    if (rst) dp_wr_q <= 1'b0;
    else if (htrans == 2'b10 && hready && hwrite) dp_wr_q <= 1'b1;
    else if (hready) dp_wr_q <= 1'b0;
  end

  assert_nonseq_once_R1: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10 && hready) |=> htrans == 2'b00);

  assert_addr_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (htrans == 2'b10 && !hready) |=> (htrans == 2'b10 && $stable(haddr)));

  assert_wdata_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (dp_wr_q && !hready) |=> $stable(hwdata));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (err != 2'b00) |=> ($stable(err) && htrans == 2'b00));

  assert_no_release_on_err_R7: assert property (@(posedge clk) disable iff (rst)
    (err != 2'b00) |-> (!proc_rst_n && !host_sel));

  assert_release_order_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(proc_rst_n) |-> $past(host_sel));

  assert_host_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    host_sel |=> host_sel);

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (htrans == 2'b00 && !proc_rst_n && !host_sel && err == 2'b00));
endmodule

bind boot_copy_ahb_writer boot_copy_ahb_writer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .haddr     (haddr),
  .htrans    (htrans),
  .hwrite    (hwrite),
  .hwdata    (hwdata),
  .hready    (hready),
  .err       (err),
  .host_sel  (host_sel),
  .proc_rst_n(proc_rst_n)
);

// File: tb/boot_copy_ahb_writer_test.sv
module boot_copy_ahb_writer_test;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        dbg = 1'b0, wv = 1'b0, ad = 1'b0, cd = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] haddr, hwdata, hrdata, haddr_b, hwdata_b;
  logic [1:0]  htrans, htrans_b, err, err_b;
  logic        hwrite, hwrite_b, host_sel, host_b, proc_rst_n, proc_b;
  logic [2:0]  hsize, hburst, hsize_b, hburst_b;
  logic        hready, hresp;

  boot_copy_ahb_writer #(.BASE_ADDR(BASE), .BIG_END(1'b0)) uut (
    .clk(clk), .rst(rst), .debug_bypass(dbg), .word_valid(wv), .word_data(wd),
    .all_done(ad), .check_done(cd), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata), .hready(hready),
    .hresp(hresp), .err(err), .host_sel(host_sel), .proc_rst_n(proc_rst_n));

  boot_copy_ahb_writer #(.BASE_ADDR(BASE), .BIG_END(1'b1)) uut_be (
    .clk(clk), .rst(rst), .debug_bypass(dbg), .word_valid(wv), .word_data(wd),
    .all_done(ad), .check_done(cd), .haddr(haddr_b), .htrans(htrans_b), .hwrite(hwrite_b),
    .hsize(hsize_b), .hburst(hburst_b), .hwdata(hwdata_b), .hrdata(hrdata), .hready(hready),
    .hresp(hresp), .err(err_b), .host_sel(host_b), .proc_rst_n(proc_b));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] swap(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // AHB-Lite slave model with scoreboard monitor
  logic [31:0] mem [16];
  logic [63:0] exp_q [$];
  logic        dp_active = 1'b0, dp_write = 1'b0, err_stage = 1'b0;
  logic [31:0] dp_addr = '0, dp_wdata = '0, rd_addr_seen = '0;
  int          wait_left = 0, waits_cfg = 0, wr_cnt = 0, rd_cnt = 0, sent = 0;
  bit          err_en = 1'b0;
  logic [31:0] err_addr = '0;

  always @(posedge clk) begin
    if (rst) begin
      hready    <= 1'b1;
      hresp     <= 1'b0;
      dp_active <= 1'b0;
      err_stage <= 1'b0;
    end else begin
      if (dp_active && hready) begin
        dp_active <= 1'b0;
        hresp     <= 1'b0;
        if (dp_write && !hresp) begin
          wr_cnt++;
          mem[(dp_addr - BASE) >> 2 & 15] <= hwdata;
          chk(hwdata == dp_wdata, "R4", "write data changed during wait", hwdata, dp_wdata);
          chk(hwdata_b == swap(hwdata), "R3", "big-endian lane order", hwdata_b, swap(hwdata));
          if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected write", dp_addr, 32'h0);
          else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk(dp_addr == e[63:32], "R2", "write address", dp_addr, e[63:32]);
            chk(hwdata == e[31:0], "R3", "little-endian write data", hwdata, e[31:0]);
          end
        end
      end else if (dp_active && !hready) begin
        if (err_stage) begin
          hready    <= 1'b1;
          err_stage <= 1'b0;
        end else if (wait_left == 0) hready <= 1'b1;
        else wait_left <= wait_left - 1;
      end
      if (htrans == 2'b10 && hready) begin
        dp_active <= 1'b1;
        dp_addr   <= haddr;
        dp_write  <= hwrite;
        dp_wdata  <= hwdata;
        hrdata    <= mem[(haddr - BASE) >> 2 & 15];
        if (!hwrite) begin
          rd_cnt++;
          rd_addr_seen <= haddr;
        end
        if (err_en && haddr == err_addr) begin
          hready    <= 1'b0;
          hresp     <= 1'b1;
          err_stage <= 1'b1;
        end else if (waits_cfg > 0) begin
          hready    <= 1'b0;
          hresp     <= 1'b0;
          wait_left <= waits_cfg - 1;
        end else begin
          hready <= 1'b1;
          hresp  <= 1'b0;
        end
      end
    end
  end

  // handover order monitor
  int  cyc = 0, hs_cyc = -1, pr_cyc = -1;
  logic hs_prev = 1'b0, pr_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      hs_cyc = -1;
      pr_cyc = -1;
    end else begin
      if (host_sel && !hs_prev) hs_cyc = cyc;
      if (proc_rst_n && !pr_prev) pr_cyc = cyc;
    end
    hs_prev = host_sel;
    pr_prev = proc_rst_n;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; ad = 1'b0; cd = 1'b0; wv = 1'b0; dbg = 1'b0;
    err_en = 1'b0; waits_cfg = 0;
    exp_q.delete();
    sent = 0; wr_cnt = 0; rd_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] d);
    exp_q.push_back({BASE + 32'(4 * sent), swap(d)});
    sent++;
    wd = d;
    wv = 1'b1;
    @(negedge clk);
    wv = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic finish_copy(input bit corrupt);
    ad = 1'b1;
    repeat (5) @(negedge clk);
    if (corrupt) mem[0] = ~mem[0];
    cd = 1'b1;
    repeat (15) @(negedge clk);
  endtask

  task automatic check_handover(input string tag);
    chk(err == 2'b00, "R8", {tag, " no error"}, 32'(err), 32'h0);
    chk(host_sel == 1'b1, "R8", {tag, " host selected"}, 32'(host_sel), 32'h1);
    chk(proc_rst_n == 1'b1, "R8", {tag, " processor released"}, 32'(proc_rst_n), 32'h1);
    chk(pr_cyc == hs_cyc + 1, "R8", {tag, " release one cycle after select"},
        32'(pr_cyc - hs_cyc), 32'h1);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hDEAD_0000 + 32'(i);

    // R10 reset state, R1 fixed size and burst
    repeat (2) @(negedge clk);
    chk(htrans == 2'b00, "R10", "htrans in reset", 32'(htrans), 32'h0);
    chk(proc_rst_n == 1'b0, "R10", "proc reset in reset", 32'(proc_rst_n), 32'h0);
    chk(host_sel == 1'b0, "R10", "host_sel in reset", 32'(host_sel), 32'h0);
    chk(err == 2'b00, "R10", "err in reset", 32'(err), 32'h0);
    chk(hsize == 3'b010, "R1", "hsize", 32'(hsize), 32'h2);
    chk(hburst == 3'b000, "R1", "hburst", 32'(hburst), 32'h0);

    // plain copy, zero wait states
    do_reset();
    send_word(32'h1122_3344);
    send_word(32'hA5A5_0F0F);
    send_word(32'h0000_0001);
    send_word(32'h8000_0000);
    chk(wr_cnt == 4, "R2", "write count", 32'(wr_cnt), 32'h4);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_copy(1'b0);
    chk(rd_cnt == 1, "R6", "one read-back", 32'(rd_cnt), 32'h1);
    chk(rd_addr_seen == BASE, "R6", "read-back address", rd_addr_seen, BASE);
    check_handover("plain");

    // copy with wait states
    do_reset();
    waits_cfg = 3;
    for (int i = 0; i < 5; i++) send_word(32'h0102_0304 * 32'(i + 1));
    chk(wr_cnt == 5, "R2", "write count with waits", 32'(wr_cnt), 32'h5);
    finish_copy(1'b0);
    chk(rd_cnt == 1, "R6", "read-back with waits", 32'(rd_cnt), 32'h1);
    check_handover("waits");

    // read-back held off until check_done
    do_reset();
    send_word(32'hCAFE_F00D);
    send_word(32'h1234_5678);
    ad = 1'b1;
    repeat (20) @(negedge clk);
    chk(rd_cnt == 0, "R6", "no read before check_done", 32'(rd_cnt), 32'h0);
    chk(proc_rst_n == 1'b0, "R6", "still in reset before check_done", 32'(proc_rst_n), 32'h0);
    cd = 1'b1;
    repeat (15) @(negedge clk);
    chk(rd_cnt == 1, "R6", "read after check_done", 32'(rd_cnt), 32'h1);
    check_handover("held");

    // error response on second write
    do_reset();
    err_en = 1'b1;
    err_addr = BASE + 32'd4;
    send_word(32'h0BAD_0001);
    send_word(32'h0BAD_0002);
    send_word(32'h0BAD_0003);
    chk(wr_cnt == 1, "R5", "writes after error", 32'(wr_cnt), 32'h1);
    chk(err == 2'b01, "R5", "error bit 0", 32'(err), 32'h1);
    finish_copy(1'b0);
    chk(rd_cnt == 0, "R5", "no read-back after error", 32'(rd_cnt), 32'h0);
    chk(proc_rst_n == 1'b0, "R5", "processor held", 32'(proc_rst_n), 32'h0);
    chk(host_sel == 1'b0, "R5", "host not selected", 32'(host_sel), 32'h0);
    chk(err == 2'b01, "R5", "error bit sticky", 32'(err), 32'h1);

    // read-back mismatch
    do_reset();
    send_word(32'h5555_AAAA);
    send_word(32'h7777_8888);
    send_word(32'h9999_0000);
    finish_copy(1'b1);
    chk(rd_cnt == 1, "R7", "read-back issued", 32'(rd_cnt), 32'h1);
    chk(err == 2'b10, "R7", "mismatch flag", 32'(err), 32'h2);
    chk(proc_rst_n == 1'b0, "R7", "processor held", 32'(proc_rst_n), 32'h0);
    chk(host_sel == 1'b0, "R7", "host not selected", 32'(host_sel), 32'h0);

    // debug bypass
    do_reset();
    dbg = 1'b1;
    repeat (10) @(negedge clk);
    chk(wr_cnt == 0 && rd_cnt == 0, "R9", "no transfers in bypass",
        32'(wr_cnt + rd_cnt), 32'h0);
    check_handover("bypass");

    summary();
    $finish;
  end
endmodule